// File: doc/BRIEF.md
# Capability Load Page-Guard Checker

This block decides what happens to a capability load or atomic once the leaf page-table entry has been found. It reads four capability bits from that entry: the capability-write enable, the capability-dirty bit, the page generation bit and the user bit. It also reads the supervisor enable for generation checking, the supervisor's current user generation bit, the tag that came back from memory, and a flag that is set when a platform mechanism has already wiped that tag. From these it picks one result code and the tag value to write into the destination register.

The decision logic is combinational. The result is registered and comes out one cycle after a valid request, together with its own valid strobe.

The parameter `PRECISE_TAG` sets what happens on a generation mismatch when the loaded tag is zero. With a value of 1 the block traps only when the loaded tag is actually set. With a value of 0 it traps on every capability access whose generation does not match.

Result codes on `rsp_result` are as follows:
- 0: pass
- 1: clear the loaded tag
- 2: load capability fault
- 3: reserved page encoding
- 4: store-side fault, used when an atomic would store a tagged value to a page that cannot hold capabilities

Top module: `cap_load_pgguard`

## Requirements
- R1: `rsp_valid` equals the `req_valid` of the previous cycle. After reset, and in any cycle following a cycle without a request, `rsp_result` is 0 and `rsp_tag` is 0.
- R2: A request with `req_is_cap`=0 gives result 0 (pass) and `rsp_tag`=0, whatever the other inputs are.
- R3: A capability access with crw=0, cd=0 and crg=0 gives result 1 (clear) and `rsp_tag`=0. The same holds for any crw=0 page while `gen_en`=0, unless R10 applies.
- R4: While `gen_en`=1, a page with crw=0 and either cd=1 or crg=1 gives result 3, raises `rsp_reserved`, and gives `rsp_tag`=0. This case has the highest priority among capability accesses. `rsp_reserved` is high only together with result 3.
- R5: With crw=1 and user=0, the result is 0 (pass), whatever crg and the tag are.
- R6: With crw=1, user=1 and crg equal to `gen_status`, the result is 0 (pass).
- R7: While `gen_en`=1, an access with crw=1, user=1, crg different from `gen_status`, a set loaded tag and `tag_forced_clr`=0 gives result 2 (load fault) with `rsp_tag`=0.
- R8: For the mismatch case of R7 with a loaded tag of 0, the result is 0 when `PRECISE_TAG`=1 and 2 when `PRECISE_TAG`=0.
- R9: When `tag_forced_clr`=1, the result is never 2, and `rsp_tag` is 0.
- R10: An atomic (`req_is_amo`=1) with a set store tag on a crw=0 page that is not reserved gives result 4, which takes precedence over clearing the tag. `rsp_tag` is 0 in this case.
- R11: When the result is 0 for a capability access, `rsp_tag` equals the loaded tag ANDed with the inverse of `tag_forced_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_cap | input | 1 | Access loads a capability |
| req_is_amo | input | 1 | Access is an atomic read-modify-write |
| req_st_tag | input | 1 | Tag of the value an atomic would store |
| pte_crw | input | 1 | Page allows capability writes |
| pte_cd | input | 1 | Page capability-dirty bit |
| pte_crg | input | 1 | Page generation bit |
| pte_user | input | 1 | Page is user accessible |
| gen_en | input | 1 | Supervisor enable for generation checking |
| gen_status | input | 1 | Current user generation bit |
| tag_loaded | input | 1 | Tag returned by memory |
| tag_forced_clr | input | 1 | Platform has already wiped the tag |
| rsp_valid | output | 1 | Registered result is valid |
| rsp_result | output | 3 | Result code, listed above |
| rsp_reserved | output | 1 | Page encoding is reserved |
| rsp_tag | output | 1 | Tag to write to the destination |

## Verification
The hardest case to reach from the ports is the narrow point where the two trapping variants disagree. That point needs the generation check enabled, a user page with capability writes allowed, a generation mismatch, a loaded tag of zero, no platform wipe and a non-atomic access, all in the same request. Uniform random stimulus lands there only about once in a few hundred requests. The bench therefore builds both variants side by side and drives them with the same inputs. It adds directed requests for that exact point, for the forced-clear override, and for an atomic on a page whose encoding is both reserved and store-faulting.

// File: rtl/capg_pkg.sv
package capg_pkg;
   localparam int unsigned RES_W = 3;
   typedef enum logic [RES_W-1:0] {
      RES_PASS     = 3'd0,
      RES_CLEAR    = 3'd1,
      RES_LDFAULT  = 3'd2,
      RES_RESERVED = 3'd3,
      RES_STFAULT  = 3'd4
   } capg_res_e;

   typedef struct packed {
      logic crw;
      logic cd;
      logic crg;
      logic user;
   } capg_pte_t;

   typedef struct packed {
      logic reserved;
      logic no_capwr;
      logic gen_mismatch;
   } capg_class_t;
endpackage

// File: rtl/capg_pte_class.sv
module capg_pte_class
   import capg_pkg::*;
(
   input  capg_pte_t   pte,
   input  logic        gen_en,
   input  logic        gen_status,
   output capg_class_t cls
);
   always_comb begin
      cls.no_capwr     = !pte.crw;
      cls.reserved     = gen_en && !pte.crw && (pte.cd || pte.crg);
      cls.gen_mismatch = gen_en && pte.crw && pte.user && (pte.crg != gen_status);
   end
endmodule

// File: rtl/capg_resolve.sv
module capg_resolve
   import capg_pkg::*;
#(
   parameter bit PRECISE_TAG = 1'b1
) (
   input  logic        is_cap,
   input  logic        is_amo,
   input  logic        st_tag,
   input  capg_class_t cls,
   input  logic        tag_loaded,
   input  logic        tag_forced_clr,
   output capg_res_e   res,
   output logic        tag_out
);
   logic tag_eff;
   logic trap_fire;

   assign tag_eff = tag_loaded && !tag_forced_clr;

   generate
      if (PRECISE_TAG) begin : g_precise
         assign trap_fire = cls.gen_mismatch && tag_eff;
      end else begin : g_conservative
         assign trap_fire = cls.gen_mismatch && !tag_forced_clr;
      end
   endgenerate

   always_comb begin
      res     = RES_PASS;
      tag_out = 1'b0;
      if (is_cap) begin
         if (cls.reserved) begin
            res = RES_RESERVED;
         end else if (cls.no_capwr && is_amo && st_tag) begin
            res = RES_STFAULT;
         end else if (cls.no_capwr) begin
            res = RES_CLEAR;
         end else if (trap_fire) begin
            res = RES_LDFAULT;
         end else begin
            res     = RES_PASS;
            tag_out = tag_eff;
         end
      end
   end
endmodule

// File: rtl/cap_load_pgguard.sv
module cap_load_pgguard
   import capg_pkg::*;
#(
   parameter bit PRECISE_TAG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_is_cap,
   input  logic             req_is_amo,
   input  logic             req_st_tag,
   input  logic             pte_crw,
   input  logic             pte_cd,
   input  logic             pte_crg,
   input  logic             pte_user,
   input  logic             gen_en,
   input  logic             gen_status,
   input  logic             tag_loaded,
   input  logic             tag_forced_clr,
   output logic             rsp_valid,
   output logic [RES_W-1:0] rsp_result,
   output logic             rsp_reserved,
   output logic             rsp_tag
);
   capg_pte_t   pte;
   capg_class_t cls;
   capg_res_e   res_d;
   logic        tag_d;

   assign pte = '{crw: pte_crw, cd: pte_cd, crg: pte_crg, user: pte_user};

   capg_pte_class u_class (
      .pte        (pte),
      .gen_en     (gen_en),
      .gen_status (gen_status),
      .cls        (cls)
   );

   capg_resolve #(.PRECISE_TAG(PRECISE_TAG)) u_resolve (
      .is_cap         (req_is_cap),
      .is_amo         (req_is_amo),
      .st_tag         (req_st_tag),
      .cls            (cls),
      .tag_loaded     (tag_loaded),
      .tag_forced_clr (tag_forced_clr),
      .res            (res_d),
      .tag_out        (tag_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_result   <= RES_PASS;
         rsp_reserved <= 1'b0;
         rsp_tag      <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_result   <= req_valid ? res_d : RES_PASS;
         rsp_reserved <= req_valid && (res_d == RES_RESERVED);
         rsp_tag      <= req_valid && tag_d;
      end
   end

   // R1: valid strobe follows the request by one cycle
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_result == RES_PASS && !rsp_tag));
   // R2: non-capability loads pass
   p_noncap_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_cap) |=> (rsp_result == RES_PASS && !rsp_tag));
   // R4: reserved flag only with the reserved code, and never with a tag
   p_reserved_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_reserved |-> (rsp_result == RES_RESERVED && !rsp_tag));
   // R5: kernel pages with capability writes pass
   p_kernel_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_cap && pte_crw && !pte_user) |=> rsp_result == RES_PASS);
   // R6: matching generation passes
   p_gen_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_cap && pte_crw && pte_crg == gen_status) |=> rsp_result == RES_PASS);
   // R9: a wiped tag never faults and never comes out set
   p_forced_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tag_forced_clr) |=> (rsp_result != RES_LDFAULT && !rsp_tag));
endmodule

// File: tb/cap_load_pgguard_bench.sv
`timescale 1ns/1ps
module cap_load_pgguard_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_is_cap = 0, req_is_amo = 0, req_st_tag = 0;
   logic pte_crw = 0, pte_cd = 0, pte_crg = 0, pte_user = 0;
   logic gen_en = 0, gen_status = 0, tag_loaded = 0, tag_forced_clr = 0;
   logic       v_p, r_p, t_p, v_c, r_c, t_c;
   logic [2:0] res_p, res_c;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cap_load_pgguard #(.PRECISE_TAG(1'b1)) u_cap_load_pgguard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_cap(req_is_cap),
      .req_is_amo(req_is_amo), .req_st_tag(req_st_tag), .pte_crw(pte_crw),
      .pte_cd(pte_cd), .pte_crg(pte_crg), .pte_user(pte_user), .gen_en(gen_en),
      .gen_status(gen_status), .tag_loaded(tag_loaded), .tag_forced_clr(tag_forced_clr),
      .rsp_valid(v_p), .rsp_result(res_p), .rsp_reserved(r_p), .rsp_tag(t_p));

   cap_load_pgguard #(.PRECISE_TAG(1'b0)) u_cap_load_pgguard_cons (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_cap(req_is_cap),
      .req_is_amo(req_is_amo), .req_st_tag(req_st_tag), .pte_crw(pte_crw),
      .pte_cd(pte_cd), .pte_crg(pte_crg), .pte_user(pte_user), .gen_en(gen_en),
      .gen_status(gen_status), .tag_loaded(tag_loaded), .tag_forced_clr(tag_forced_clr),
      .rsp_valid(v_c), .rsp_result(res_c), .rsp_reserved(r_c), .rsp_tag(t_c));

   // expected result {code[2:0], tag}
   function automatic logic [3:0] model(input bit precise);
      if (!req_valid || !req_is_cap) return 4'b0000;            // R1 R2
      if (gen_en && !pte_crw && (pte_cd || pte_crg)) return {3'd3, 1'b0}; // R4
      if (!pte_crw && req_is_amo && req_st_tag) return {3'd4, 1'b0};      // R10
      if (!pte_crw) return {3'd1, 1'b0};                        // R3
      if (gen_en && pte_user && pte_crg != gen_status && !tag_forced_clr) begin
         if (tag_loaded || !precise) return {3'd2, 1'b0};       // R7 R8
      end
      return {3'd0, tag_loaded & ~tag_forced_clr};              // R5 R6 R9 R11
   endfunction

   function automatic string req_of(input logic [3:0] e);
      case (e[3:1])
         3'd1: return "R3";
         3'd2: return "R7/R8";
         3'd3: return "R4";
         3'd4: return "R10";
         default: return (req_valid && req_is_cap) ? "R11" : "R2";
      endcase
   endfunction

   task automatic check_one(input string nm, input logic v, input logic [2:0] r,
                            input logic rs, input logic t, input logic [3:0] e,
                            input logic ev, input string rq);
      checks++;
      if (v !== ev || r !== e[3:1] || t !== e[0] || rs !== (e[3:1] == 3'd3)) begin
         fails++;
         $display("FAIL %s %s: got v=%0b res=%0d rsv=%0b tag=%0b exp v=%0b res=%0d rsv=%0b tag=%0b",
                  rq, nm, v, r, rs, t, ev, e[3:1], (e[3:1] == 3'd3), e[0]);
      end
   endtask

   task automatic apply_and_check;
      logic [3:0] ep, ec;
      logic ev;
      string rq;
      ep = model(1'b1);
      ec = model(1'b0);
      ev = req_valid;
      rq = req_of(ep);
      @(posedge clk);
      @(negedge clk);
      check_one("precise", v_p, res_p, r_p, t_p, ep, ev, rq);       // R1 timing
      check_one("conservative", v_c, res_c, r_c, t_c, ec, ev, req_of(ec));
   endtask

   task automatic drive(input logic [11:0] b);
      {req_valid, req_is_cap, req_is_amo, req_st_tag, pte_crw, pte_cd,
       pte_crg, pte_user, gen_en, gen_status, tag_loaded, tag_forced_clr} = b;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      if (!done) $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (v_p !== 0 || res_p !== 0 || t_p !== 0 || r_p !== 0) begin
         fails++;
         $display("FAIL R1 reset: got v=%0b res=%0d tag=%0b exp 0 0 0", v_p, res_p, t_p);
      end
      rst_n = 1'b1;
      // directed corners
      //       vld cap amo st crw cd crg u en st tag fc
      drive(12'b1_1_0_0_1_0_1_1_1_0_0_0); apply_and_check; // R8 precise/cons split
      drive(12'b1_1_0_0_1_0_1_1_1_0_1_0); apply_and_check; // R7
      drive(12'b1_1_0_0_1_0_1_1_1_0_1_1); apply_and_check; // R9 forced clear
      drive(12'b1_1_1_1_0_1_0_0_1_0_1_0); apply_and_check; // R4 over R10
      drive(12'b1_1_1_1_0_0_0_0_1_0_1_0); apply_and_check; // R10
      drive(12'b1_1_1_0_0_0_0_0_1_0_1_0); apply_and_check; // R3
      drive(12'b1_1_0_0_0_1_1_0_0_0_1_0); apply_and_check; // R3 with gen_en off
      drive(12'b1_1_0_0_1_0_1_0_1_0_1_0); apply_and_check; // R5
      drive(12'b1_1_0_0_1_0_1_1_1_1_1_0); apply_and_check; // R6 / R11
      drive(12'b1_0_0_0_0_1_1_1_1_0_1_0); apply_and_check; // R2
      drive(12'b0_1_0_0_1_0_1_1_1_0_1_0); apply_and_check; // R1 idle
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [11:0] b;
         b = 12'($urandom);
         b[11] = ($urandom_range(0, 7) != 0);
         b[10] = ($urandom_range(0, 7) != 0);
         b[3]  = ($urandom_range(0, 3) != 0);
         drive(b);
         apply_and_check;
      end
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule